// File: doc/BRIEF.md
# Transmit Phase-Align Buffer

This block is a small dual-clock buffer that hands 16-bit words from a parallel input register, clocked by `wr_clk`, to the character-rate domain of a serializer, clocked by `rd_clk`. Both clocks run at the same nominal rate with a fixed but unknown phase between them. When reset is released, the read side waits until the synchronized write pointer is far enough ahead. It then places its read pointer a fixed number of entries behind. That spacing is the working point and it is held from then on, so a slow phase wander of the write clock is absorbed without any action.

If the read side finds the buffer empty (underflow) or the write side finds it full (overflow), the error output rises. The read side then flushes for a fixed nine character cycles, during which the output word is the alternating idle pattern `16'hAAAA`. After the flush it re-centres its read pointer on the current write pointer and resumes, with no external help. Pulling the active-low asynchronous reset clears the error at once and holds the block in its initial state, with the idle pattern on the output. Bit 15 of each output word is the one the downstream shifter sends first.

The read side is a three-state machine. ARM waits for the write pointer and moves to RUN on the *arm* transition, once the synchronized write pointer has advanced by the centring distance. RUN streams words and moves to FLUSH on the *fault* transition, when it sees an underflow or a synchronized overflow flag. FLUSH outputs the idle word for nine cycles and returns to RUN on the *recover* transition, re-centring the read pointer as it goes. Reset forces ARM from any state.

Top module: `txpa_fifo`

## Requirements
- R1: With `wr_clk` and `rd_clk` at the same frequency and any fixed phase between them, each non-idle word on `rd_data` is the word written one write cycle after the previous output word (no loss, no repeat), and `err` stays low.
- R2: While `rst_n` is low, `err` is 0 and `rd_data` is `16'hAAAA` (bit 15 = 1, the first bit sent, then alternating). Both take effect asynchronously.
- R3: After `rst_n` rises, `rd_data` stays `16'hAAAA` for at least the first read cycle. Written words start to appear within 20 read cycles.
- R4: When the write clock is slower than the read clock, the resulting underflow drives `err` high.
- R5: When the write clock is faster than the read clock, the resulting overflow drives `err` high.
- R6: Each self-clearing error lasts exactly 9 `rd_clk` cycles, with `rd_data` = `16'hAAAA` in every one of them. `err` then falls without any reset.
- R7: Driving `rst_n` low while `err` is high clears `err` immediately.
- R8: After a self-clearing error, once the clock rates are equal again, the output resumes as an unbroken run of consecutive written words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_clk | input | 1 | Write (input register) clock |
| wr_data | input | 16 | Word captured on every `wr_clk` rising edge |
| rd_clk | input | 1 | Character-rate read clock |
| rd_data | output | 16 | Word toward the serializer, bit 15 sent first |
| err | output | 1 | High during an overflow or underflow flush |

## Verification
The hardest situation to reach from the ports is the recovery path, where the flush has ended and the read pointer has been re-centred onto a write pointer that kept moving throughout the flush. The bench reaches it by stretching the write clock period until an underflow fires. At the first sampled error cycle it returns the write clock to the read rate, so the nine-cycle flush and the re-centring happen under normal rates. It then checks both the flush length and the continuity of the resumed stream. Overflow is provoked the same way with a shortened write period, and the fixed-phase cases come from skewing the write clock once before reset release.

// File: rtl/txpa_pkg.sv
package txpa_pkg;
    typedef enum logic [1:0] {
        RD_ARM   = 2'd0,
        RD_RUN   = 2'd1,
        RD_FLUSH = 2'd2
    } rd_state_e;
endpackage

// File: rtl/pa_rst_sync.sv
module pa_rst_sync (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [1:0] stage;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage <= 2'b00;
        else         stage <= {stage[0], 1'b1};
    end

    assign srst_n = stage[1];
endmodule

// File: rtl/pa_sync_vec.sv
module pa_sync_vec #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pa_wr_side.sv
module pa_wr_side #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int PW     = 5
) (
    input  logic                           wr_clk,
    input  logic                           wr_srst_n,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [PW-1:0]                  rgray_s,
    input  logic                           flush_s,
    output logic [DEPTH-1:0][DATA_W-1:0]   mem,
    output logic [PW-1:0]                  wgray,
    output logic                           ovf
);
    localparam int AW = $clog2(DEPTH);

    logic [PW-1:0] wbin;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] used;
    logic [1:0]    guard;

    // Gray to binary on the synchronized read pointer
    always_comb begin
        for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
    end

    assign used = wbin - rbin_s;

    always_ff @(posedge wr_clk or negedge wr_srst_n) begin
        if (!wr_srst_n) begin
            wbin  <= '0;
            wgray <= '0;
            guard <= 2'b00;
            ovf   <= 1'b0;
        end else begin
            wbin  <= wbin + PW'(1);
            wgray <= wbin ^ (wbin >> 1);
            guard <= {guard[0], flush_s};
            // the read pointer jumps at flush exit; skip checks until it settles
            if (flush_s)
                ovf <= 1'b0;
            else if (guard == 2'b00 && used >= PW'(DEPTH))
                ovf <= 1'b1;
        end
    end

    always_ff @(posedge wr_clk) begin
        mem[wbin[AW-1:0]] <= wr_data;
    end
endmodule

// File: rtl/pa_rd_ctrl.sv
module pa_rd_ctrl
    import txpa_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int DEPTH     = 16,
    parameter int PW        = 5,
    parameter int CENTER    = 4,
    parameter int FLUSH_CYC = 9
) (
    input  logic                           rd_clk,
    input  logic                           rd_srst_n,
    input  logic [PW-1:0]                  wgray_s,
    input  logic                           ovf_s,
    input  logic [DEPTH-1:0][DATA_W-1:0]   mem,
    output logic [DATA_W-1:0]              rd_data,
    output logic                           err,
    output logic [PW-1:0]                  rgray,
    output logic                           flush_q,
    output logic                           fault,
    output logic [PW-1:0]                  rd_ptr,
    output logic                           running
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(FLUSH_CYC + 1);
    localparam logic [DATA_W-1:0] IDLE_WORD = {(DATA_W/2){2'b10}};

    rd_state_e     state, nstate;
    logic [PW-1:0] rbin;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] avail;
    logic [PW-1:0] recenter;
    logic [CW-1:0] cnt;
    logic          arm_ok;
    logic          flush_done;

    always_comb begin
        for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    assign avail      = wbin_s - rbin;
    assign recenter   = wbin_s - PW'(CENTER);
    assign arm_ok     = (wbin_s >= PW'(CENTER)) && (wbin_s < PW'(DEPTH));
    assign fault      = (avail == '0) || ovf_s;
    assign flush_done = (cnt == CW'(FLUSH_CYC - 1));
    assign rd_ptr     = rbin;
    assign running    = (state == RD_RUN);

    // next-state logic: arm, fault, recover
    always_comb begin
        nstate = state;
        unique case (state)
            RD_ARM:   if (arm_ok)     nstate = RD_RUN;
            RD_RUN:   if (fault)      nstate = RD_FLUSH;
            RD_FLUSH: if (flush_done) nstate = RD_RUN;
            default:                  nstate = RD_ARM;
        endcase
    end

    // state register
    always_ff @(posedge rd_clk or negedge rd_srst_n) begin
        if (!rd_srst_n) state <= RD_ARM;
        else            state <= nstate;
    end

    // outputs and datapath
    always_ff @(posedge rd_clk or negedge rd_srst_n) begin
        if (!rd_srst_n) begin
            rbin    <= '0;
            cnt     <= '0;
            rd_data <= IDLE_WORD;
            err     <= 1'b0;
            rgray   <= '0;
            flush_q <= 1'b0;
        end else begin
            rgray   <= rbin ^ (rbin >> 1);
            flush_q <= (state == RD_FLUSH);
            unique case (state)
                RD_ARM: begin
                    rd_data <= IDLE_WORD;
                    err     <= 1'b0;
                    cnt     <= '0;
                    if (arm_ok) rbin <= recenter;
                end
                RD_RUN: begin
                    cnt <= '0;
                    if (fault) begin
                        rd_data <= IDLE_WORD;
                        err     <= 1'b1;
                    end else begin
                        rd_data <= mem[rbin[AW-1:0]];
                        rbin    <= rbin + PW'(1);
                        err     <= 1'b0;
                    end
                end
                RD_FLUSH: begin
                    rd_data <= IDLE_WORD;
                    if (flush_done) begin
                        err  <= 1'b0;
                        cnt  <= '0;
                        rbin <= recenter;
                    end else begin
                        err <= 1'b1;
                        cnt <= cnt + CW'(1);
                    end
                end
                default: begin
                    rd_data <= IDLE_WORD;
                    err     <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/txpa_fifo.sv
module txpa_fifo #(
    parameter int DATA_W    = 16,
    parameter int DEPTH     = 16,
    parameter int FLUSH_CYC = 9
) (
    input  logic              rst_n,
    input  logic              wr_clk,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    output logic [DATA_W-1:0] rd_data,
    output logic              err
);
    localparam int PW     = $clog2(DEPTH) + 1;
    localparam int CENTER = DEPTH / 4;

    logic                         wr_srst_n, rd_srst_n;
    logic [DEPTH-1:0][DATA_W-1:0] mem;
    logic [PW-1:0]                wgray, wgray_s, rgray, rgray_s;
    logic                         ovf, ovf_s, flush_q, flush_s;
    logic                         rd_fault, rd_running;
    logic [PW-1:0]                rd_ptr;

    pa_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wr_srst_n));
    pa_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rd_srst_n));

    pa_sync_vec #(.W(PW)) u_wptr_sync (.clk(rd_clk), .rst_n(rd_srst_n), .d(wgray),   .q(wgray_s));
    pa_sync_vec #(.W(PW)) u_rptr_sync (.clk(wr_clk), .rst_n(wr_srst_n), .d(rgray),   .q(rgray_s));
    pa_sync_vec #(.W(1))  u_ovf_sync  (.clk(rd_clk), .rst_n(rd_srst_n), .d(ovf),     .q(ovf_s));
    pa_sync_vec #(.W(1))  u_fl_sync   (.clk(wr_clk), .rst_n(wr_srst_n), .d(flush_q), .q(flush_s));

    pa_wr_side #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PW(PW)) u_wr (
        .wr_clk(wr_clk), .wr_srst_n(wr_srst_n), .wr_data(wr_data),
        .rgray_s(rgray_s), .flush_s(flush_s),
        .mem(mem), .wgray(wgray), .ovf(ovf)
    );

    pa_rd_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PW(PW),
                 .CENTER(CENTER), .FLUSH_CYC(FLUSH_CYC)) u_rd (
        .rd_clk(rd_clk), .rd_srst_n(rd_srst_n), .wgray_s(wgray_s),
        .ovf_s(ovf_s), .mem(mem), .rd_data(rd_data), .err(err),
        .rgray(rgray), .flush_q(flush_q), .fault(rd_fault),
        .rd_ptr(rd_ptr), .running(rd_running)
    );
endmodule

// File: rtl/txpa_fifo_chk.sv
module txpa_fifo_chk #(
    parameter int DATA_W    = 16,
    parameter int PW        = 5,
    parameter int FLUSH_CYC = 9
) (
    input logic              rd_clk,
    input logic              rd_srst_n,
    input logic              err,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_fault,
    input logic [PW-1:0]     rd_ptr,
    input logic              rd_running
);
    localparam logic [DATA_W-1:0] IDLE_WORD = {(DATA_W/2){2'b10}};

    int unsigned   errcnt;
    logic [PW-1:0] prev_ptr;
    logic          prev_run;
    logic [PW-1:0] step;

    always_ff @(posedge rd_clk or negedge rd_srst_n) begin
        if (!rd_srst_n) begin
            errcnt   <= 0;
            prev_ptr <= '0;
            prev_run <= 1'b0;
        end else begin
            errcnt   <= err ? errcnt + 1 : 0;
            prev_ptr <= rd_ptr;
            prev_run <= rd_running;
        end
    end

    assign step = rd_ptr - prev_ptr;

    AST_ERR_IDLE_WORD: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
        err |-> rd_data == IDLE_WORD); // R6
    AST_FLUSH_LENGTH: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
        $fell(err) |-> errcnt == FLUSH_CYC); // R6
    AST_ERR_RUN_BOUND: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
        errcnt <= FLUSH_CYC); // R6
    AST_ERR_HAS_CAUSE: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
        $rose(err) |-> $past(rd_fault)); // R4
    AST_READ_STEP: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
        (rd_running && prev_run) |-> step <= PW'(1)); // R1
endmodule

bind txpa_fifo txpa_fifo_chk #(.DATA_W(DATA_W), .PW(PW), .FLUSH_CYC(FLUSH_CYC)) u_chk (
    .rd_clk(rd_clk), .rd_srst_n(rd_srst_n), .err(err), .rd_data(rd_data),
    .rd_fault(rd_fault), .rd_ptr(rd_ptr), .rd_running(rd_running)
);

// File: tb/test_txpa_fifo.sv
`timescale 1ns/100ps
module test_txpa_fifo;
    localparam logic [15:0] IDLE = 16'hAAAA;
    localparam int NV = 6;
    // skew (100 ps units), write half period (100 ps units), error expected
    localparam int VEC [NV][3] = '{
        '{0,  20, 0},
        '{7,  20, 0},
        '{13, 20, 0},
        '{19, 20, 0},
        '{20, 30, 1},
        '{5,  12, 1}
    };

    logic        rst_n, wr_clk, rd_clk, err;
    logic [15:0] wr_data, rd_data;
    real         wr_half = 2.0;
    real         wr_skew = 0.0;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;

    txpa_fifo i_txpa_fifo (
        .rst_n(rst_n), .wr_clk(wr_clk), .wr_data(wr_data),
        .rd_clk(rd_clk), .rd_data(rd_data), .err(err)
    );

    initial begin
        rd_clk = 0;
        forever #2 rd_clk = ~rd_clk;
    end

    initial begin
        wr_clk = 0;
        forever begin
            if (wr_skew > 0.0) begin
                #(wr_skew);
                wr_skew = 0.0;
            end
            #(wr_half) wr_clk = ~wr_clk;
        end
    end

    initial begin
        wr_data = 16'h0000;
        forever begin
            @(negedge wr_clk);
            wr_data = wr_data + 16'd1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    task automatic watch(input int ncyc, output int breaks, output int words, output bit saw_err);
        logic [15:0] prev;
        bit          have;
        breaks = 0; words = 0; saw_err = 0; have = 0; prev = '0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge rd_clk);
            if (err) saw_err = 1;
            if (rd_data != IDLE) begin
                if (have && rd_data != prev + 16'd1) breaks++;
                prev = rd_data;
                have = 1;
                words++;
            end else begin
                have = 0;
            end
        end
    endtask

    task automatic wait_err(output bit seen);
        seen = 0;
        for (int c = 0; c < 400 && !seen; c++) begin
            @(negedge rd_clk);
            if (err) seen = 1;
        end
    endtask

    task automatic restart(input real half, input real skew);
        @(negedge rd_clk);
        rst_n = 0;
        wr_half = half;
        wr_skew = skew;
        repeat (6) @(negedge rd_clk);
        check(rd_data == IDLE && err == 1'b0, "R2 reset state", {rd_data, 15'd0, err}, {IDLE, 16'd0});
        rst_n = 1;
    endtask

    initial begin
        int  breaks, words, first;
        bit  saw, seen;
        rst_n = 0;
        repeat (4) @(negedge rd_clk);
        check(rd_data == IDLE, "R2 idle word at power-up", rd_data, IDLE);
        check(rd_data[15] == 1'b1, "R2 first sent bit", rd_data[15], 1);
        check(err == 1'b0, "R2 err low in reset", err, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            restart(VEC[v][1] / 10.0, VEC[v][0] / 10.0);
            watch(160, breaks, words, saw);
            if (VEC[v][2] == 0) begin
                check(!saw, "R1 no error at equal rate", saw, 0);
                check(breaks == 0, "R1 stream continuity", breaks, 0);
                check(words > 120, "R1 words delivered", words, 121);
            end else if (VEC[v][1] > 20) begin
                check(saw, "R4 underflow flagged", saw, 1);
            end else begin
                check(saw, "R5 overflow flagged", saw, 1);
            end
        end

        // R3: start-up sequence
        restart(2.0, 0.0);
        @(negedge rd_clk);
        check(rd_data == IDLE, "R3 idle right after release", rd_data, IDLE);
        first = -1;
        for (int c = 0; c < 30 && first < 0; c++) begin
            @(negedge rd_clk);
            if (rd_data != IDLE) first = c + 2;
        end
        check(first > 0 && first <= 20, "R3 stream start latency", first, 20);

        // R6 / R8: self-clearing flush then recovery
        restart(3.0, 0.0);
        wait_err(seen);
        wr_half = 2.0;
        check(seen, "R4 underflow before flush", seen, 1);
        begin
            int len, bad;
            len = 0; bad = 0;
            while (err && len < 40) begin
                if (rd_data != IDLE) bad++;
                len++;
                @(negedge rd_clk);
            end
            check(len == 9, "R6 flush length", len, 9);
            check(bad == 0, "R6 idle word during flush", bad, 0);
        end
        repeat (10) @(negedge rd_clk);
        watch(60, breaks, words, saw);
        check(!saw, "R8 no error after recovery", saw, 0);
        check(breaks == 0 && words == 60, "R8 resumed stream", {breaks[15:0], words[15:0]}, 60);

        // R7: external reset clears a pending error
        restart(3.0, 0.0);
        wait_err(seen);
        check(seen, "R7 error present before reset", seen, 1);
        rst_n = 0;
        #0.5;
        check(err == 1'b0, "R7 err cleared by reset", err, 0);
        check(rd_data == IDLE, "R7 idle word on reset", rd_data, IDLE);
        wr_half = 2.0;
        repeat (4) @(negedge rd_clk);
        rst_n = 1;
        repeat (4) @(negedge rd_clk);
        wrap_up();
    end

    initial begin
        repeat (150000) @(posedge rd_clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        wrap_up();
    end
endmodule